// File: doc/BRIEF.md
# UART Interrupt Source Identification

This block collects the interrupt conditions of a FIFO-capable serial port and reduces them to one identification byte and one interrupt line. Four enable bits choose which conditions may raise the interrupt. The event conditions come in from the surrounding receiver, transmitter and modem-status logic. These are a line-status error, receive data at or above the trigger level, a receive character timeout, the transmit holding register becoming empty, and a modem-status change. The byte always names the single most urgent condition that is both pending and enabled.

Each latched condition stays pending until the register access that services it. Reading the line status register, reading the receive buffer or reading the modem status register clears the matching condition. The holding-register-empty condition clears on a write to the holding register, or on a read of the identification byte while that byte names it. The identification byte and the interrupt line are registered outputs. The serial data path, the FIFOs and the bit-rate timing stay outside the block and appear only as input strobes and levels.

Top module: `uart_int_ident`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `iir` reads 0x01 and `irq` is low.
- R2: `iir[0]` is 0 when at least one enabled condition is pending and 1 otherwise. `irq` is high exactly when `iir[0]` is 0. When `iir[0]` is 1, bits 3:1 read 000.
- R3: Only the highest-priority enabled pending condition is reported, in this order from highest to lowest. A line-status error gives `iir[3:0]`=0x6. Receive data gives 0x4, and a receive timeout gives 0xC. A holding register empty gives 0x2. A modem-status change gives 0x0.
- R4: The timeout condition is reported only while `fifo_mode` is 1. `iir[3]` is 0 whenever `fifo_mode` was 0 in the previous cycle. Receive data and timeout share one priority level, and receive data wins when both are present.
- R5: `iir[5:4]` always read 00. `iir[7:6]` read 11 when `fifo_mode` was 1 in the previous cycle, and 00 when it was 0.
- R6: `ier[0]` enables receive data and timeout. `ier[1]` enables holding register empty. `ier[2]` enables line status, and `ier[3]` enables modem status. A disabled condition is not reported but stays pending, so it appears as soon as its enable bit is set.
- R7: A `rd_lsr` pulse clears the line-status condition, and a `rd_msr` pulse clears the modem-status condition.
- R8: The receive data condition follows the `rx_trig_lvl` level directly. A `rd_rbr` pulse clears the timeout condition.
- R9: The holding-register-empty condition clears on a `wr_thr` pulse. It also clears on a `rd_iir` pulse given while `iir[3:0]` reads 0x2, and on no other `rd_iir` pulse.
- R10: An event pulse in cycle k shows in `iir` from cycle k+2 on. A clear pulse removes the condition from `iir` from cycle k+2 on. When a set and a clear of the same condition arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier | input | 4 | Interrupt enable bits |
| fifo_mode | input | 1 | FIFO mode selected |
| ls_err_evt | input | 1 | Pulse: line-status error detected |
| rx_trig_lvl | input | 1 | Level: receive data at or above trigger |
| rx_tmo_evt | input | 1 | Pulse: receive character timeout |
| thr_empty_evt | input | 1 | Pulse: holding register became empty |
| msr_chg_evt | input | 1 | Pulse: modem-status input changed |
| rd_lsr | input | 1 | Line status register read strobe |
| rd_rbr | input | 1 | Receive buffer read strobe |
| rd_iir | input | 1 | Identification byte read strobe |
| wr_thr | input | 1 | Holding register write strobe |
| rd_msr | input | 1 | Modem status register read strobe |
| iir | output | 8 | Registered identification byte |
| irq | output | 1 | Registered interrupt output, active high |

## Verification
Each condition is first raised on its own, which shows its code and the access that clears it. All conditions are then raised at once and serviced one at a time, so the bench sees the code fall through every priority level in order. Further patterns bring the enables up after the events, switch FIFO mode on and off around a timeout, and read the identification byte while it names a condition other than the holding register. These separate a wrong priority or code from a missing mask, from a lost pending state, and from a side effect that reaches the wrong source. A set and a clear of the same condition in the same cycle, together with a sample taken one cycle too early, check the collision rule and the two-cycle latency.

// File: rtl/uart_int_pkg.sv
package uart_int_pkg;
  localparam int IER_W  = 4;
  localparam int IIR_W  = 8;
  localparam int NLAT   = 4;  // latched sources
  // latched source indices
  localparam int S_LS   = 0;
  localparam int S_TO   = 1;
  localparam int S_TH   = 2;
  localparam int S_MS   = 3;
  // enable bit positions
  localparam int E_RX   = 0;
  localparam int E_TH   = 1;
  localparam int E_LS   = 2;
  localparam int E_MS   = 3;
  // identification codes, bits 3:1
  localparam logic [2:0] C_LS = 3'b011;
  localparam logic [2:0] C_RX = 3'b010;
  localparam logic [2:0] C_TO = 3'b110;
  localparam logic [2:0] C_TH = 3'b001;
  localparam logic [2:0] C_MS = 3'b000;
  localparam logic [IIR_W-1:0] IIR_IDLE = 8'h01;
endpackage

// File: rtl/pend_latch.sv
module pend_latch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)         q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/int_prio_enc.sv
module int_prio_enc
  import uart_int_pkg::*;
(
  input  logic [NLAT-1:0]  pend,
  input  logic             rx_lvl,
  input  logic [IER_W-1:0] ier,
  input  logic             fifo_mode,
  output logic [IIR_W-1:0] id
);
  logic ls_on, rx_on, to_on, th_on, ms_on, any_on;
  logic [2:0] code;

  always_comb begin
    ls_on  = pend[S_LS] & ier[E_LS];
    rx_on  = rx_lvl & ier[E_RX];
    to_on  = pend[S_TO] & ier[E_RX] & fifo_mode;
    th_on  = pend[S_TH] & ier[E_TH];
    ms_on  = pend[S_MS] & ier[E_MS];
    any_on = ls_on | rx_on | to_on | th_on | ms_on;
    if (ls_on)      code = C_LS;
    else if (rx_on) code = C_RX;
    else if (to_on) code = C_TO;
    else if (th_on) code = C_TH;
    else            code = C_MS;
    id = {{2{fifo_mode}}, 2'b00, code, ~any_on};
  end
endmodule

// File: rtl/id_out_reg.sv
module id_out_reg #(
  parameter int               W   = 8,
  parameter logic [W-1:0]     RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= RST;
      irq <= ~RST[0];
    end else begin
      q   <= d;
      irq <= ~d[0];
    end
  end
endmodule

// File: rtl/uart_int_ident.sv
module uart_int_ident
  import uart_int_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [IER_W-1:0] ier,
  input  logic             fifo_mode,
  input  logic             ls_err_evt,
  input  logic             rx_trig_lvl,
  input  logic             rx_tmo_evt,
  input  logic             thr_empty_evt,
  input  logic             msr_chg_evt,
  input  logic             rd_lsr,
  input  logic             rd_rbr,
  input  logic             rd_iir,
  input  logic             wr_thr,
  input  logic             rd_msr,
  output logic [IIR_W-1:0] iir,
  output logic             irq
);
  logic [NLAT-1:0]  set_v, clr_v, pend;
  logic [IIR_W-1:0] id_nxt;
  logic             th_seen;

  // holding-register source is serviced by a read that reports it
  assign th_seen = rd_iir && (iir[3:0] == {C_TH, 1'b0});

  always_comb begin
    set_v       = '0;
    clr_v       = '0;
    set_v[S_LS] = ls_err_evt;
    set_v[S_TO] = rx_tmo_evt;
    set_v[S_TH] = thr_empty_evt;
    set_v[S_MS] = msr_chg_evt;
    clr_v[S_LS] = rd_lsr;
    clr_v[S_TO] = rd_rbr;
    clr_v[S_TH] = wr_thr | th_seen;
    clr_v[S_MS] = rd_msr;
  end

  pend_latch #(.W(NLAT)) u_pend (
    .clk(clk), .rst(rst), .set(set_v), .clr(clr_v), .q(pend)
  );

  int_prio_enc u_enc (
    .pend(pend), .rx_lvl(rx_trig_lvl), .ier(ier),
    .fifo_mode(fifo_mode), .id(id_nxt)
  );

  id_out_reg #(.W(IIR_W), .RST(IIR_IDLE)) u_out (
    .clk(clk), .rst(rst), .d(id_nxt), .q(iir), .irq(irq)
  );
endmodule

// File: rtl/uart_int_ident_chk.sv
module uart_int_ident_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] ier,
  input logic       fifo_mode,
  input logic       ls_err_evt,
  input logic [7:0] iir,
  input logic       irq
);
  // R2
  irq_agree_chk: assert property (@(posedge clk) disable iff (rst)
    irq == !iir[0]);

  // R2
  idle_code_chk: assert property (@(posedge clk) disable iff (rst)
    iir[0] |-> (iir[3:1] == 3'b000));

  // R5
  zero_mid_chk: assert property (@(posedge clk) disable iff (rst)
    iir[5:4] == 2'b00);

  // R5
  fifo_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (iir[7:6] == {2{$past(fifo_mode)}}));

  // R4
  no_tmo_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(fifo_mode)) |-> !iir[3]);

  // R10
  ls_latency_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst, 2) && $past(ls_err_evt, 2) && $past(ier[2]))
      |-> (iir[3:0] == 4'h6));
endmodule

bind uart_int_ident uart_int_ident_chk u_chk (
  .clk(clk), .rst(rst), .ier(ier), .fifo_mode(fifo_mode),
  .ls_err_evt(ls_err_evt), .iir(iir), .irq(irq)
);

// File: tb/uart_int_ident_test.sv
module uart_int_ident_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] ier = 4'h0;
  logic       fifo_mode = 1'b0;
  logic       ls_err_evt = 1'b0, rx_trig_lvl = 1'b0, rx_tmo_evt = 1'b0;
  logic       thr_empty_evt = 1'b0, msr_chg_evt = 1'b0;
  logic       rd_lsr = 1'b0, rd_rbr = 1'b0, rd_iir = 1'b0;
  logic       wr_thr = 1'b0, rd_msr = 1'b0;
  logic [7:0] iir;
  logic       irq;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  uart_int_ident uut (
    .clk(clk), .rst(rst), .ier(ier), .fifo_mode(fifo_mode),
    .ls_err_evt(ls_err_evt), .rx_trig_lvl(rx_trig_lvl),
    .rx_tmo_evt(rx_tmo_evt), .thr_empty_evt(thr_empty_evt),
    .msr_chg_evt(msr_chg_evt), .rd_lsr(rd_lsr), .rd_rbr(rd_rbr),
    .rd_iir(rd_iir), .wr_thr(wr_thr), .rd_msr(rd_msr),
    .iir(iir), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] exp);
    n_chk++;
    if (iir !== exp || irq !== ~exp[0]) begin
      n_bad++;
      $display("FAIL %s: iir=%02h irq=%b expected iir=%02h irq=%b",
               req, iir, irq, exp, ~exp[0]);
    end
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  // one-cycle pulse on a chosen strobe, then wait until it is visible
  task automatic pulse(input int which);
    case (which)
      0: ls_err_evt = 1'b1;   1: rx_tmo_evt = 1'b1;
      2: thr_empty_evt = 1'b1; 3: msr_chg_evt = 1'b1;
      4: rd_lsr = 1'b1;       5: rd_rbr = 1'b1;
      6: rd_iir = 1'b1;       7: wr_thr = 1'b1;
      default: rd_msr = 1'b1;
    endcase
    @(negedge clk);
    {ls_err_evt, rx_tmo_evt, thr_empty_evt, msr_chg_evt} = '0;
    {rd_lsr, rd_rbr, rd_iir, wr_thr, rd_msr} = '0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 in reset", 8'h01);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", 8'h01);
  endtask

  task automatic t_single();
    ier = 4'hF;
    pulse(0); chk("R3 line status", 8'h06);
    pulse(4); chk("R7 rd_lsr clears", 8'h01);
    rx_trig_lvl = 1'b1; settle(); chk("R8 rx level", 8'h04);
    rx_trig_lvl = 1'b0; settle(); chk("R8 rx level gone", 8'h01);
    pulse(2); chk("R3 holding empty", 8'h02);
    pulse(7); chk("R9 wr_thr clears", 8'h01);
    pulse(3); chk("R3 modem", 8'h00);
    pulse(8); chk("R7 rd_msr clears", 8'h01);
  endtask

  task automatic t_priority();
    thr_empty_evt = 1'b1; msr_chg_evt = 1'b1; ls_err_evt = 1'b1;
    rx_trig_lvl = 1'b1;
    @(negedge clk);
    {thr_empty_evt, msr_chg_evt, ls_err_evt} = '0;
    @(negedge clk);
    chk("R3 all pending", 8'h06);
    pulse(4); chk("R3 next rx", 8'h04);
    rx_trig_lvl = 1'b0; settle(); chk("R3 next holding", 8'h02);
    pulse(7); chk("R3 next modem", 8'h00);
    pulse(8); chk("R3 none left", 8'h01);
  endtask

  task automatic t_timeout();
    pulse(1); chk("R4 timeout hidden outside fifo", 8'h01);
    pulse(5);
    fifo_mode = 1'b1; settle(); chk("R5 fifo idle", 8'hC1);
    pulse(1); chk("R4 timeout in fifo", 8'hCC);
    rx_trig_lvl = 1'b1; settle(); chk("R4 rx beats timeout", 8'hC4);
    rx_trig_lvl = 1'b0; settle(); chk("R4 timeout remains", 8'hCC);
    pulse(5); chk("R8 rd_rbr clears timeout", 8'hC1);
    fifo_mode = 1'b0; settle(); chk("R5 flags off", 8'h01);
  endtask

  task automatic t_enable();
    ier = 4'h0;
    pulse(0); pulse(3); chk("R6 all masked", 8'h01);
    ier = 4'h8; settle(); chk("R6 modem enable bit3", 8'h00);
    ier = 4'hC; settle(); chk("R6 line enable bit2", 8'h06);
    pulse(4); pulse(8);
    ier = 4'h1; pulse(2); chk("R6 holding masked", 8'h01);
    ier = 4'h2; settle(); chk("R6 holding enable bit1", 8'h02);
    pulse(7); ier = 4'hF; settle(); chk("R6 back to idle", 8'h01);
  endtask

  task automatic t_iir_read();
    pulse(2); chk("R9 holding shown", 8'h02);
    pulse(6); chk("R9 read of iir clears", 8'h01);
    pulse(2); pulse(0); chk("R9 line over holding", 8'h06);
    pulse(6); chk("R9 other read keeps", 8'h06);
    pulse(4); chk("R9 holding survives", 8'h02);
    pulse(6); chk("R9 now cleared", 8'h01);
  endtask

  task automatic t_timing();
    msr_chg_evt = 1'b1; rd_msr = 1'b1;
    @(negedge clk);
    msr_chg_evt = 1'b0; rd_msr = 1'b0;
    @(negedge clk);
    chk("R10 set wins over clear", 8'h00);
    pulse(8);
    ls_err_evt = 1'b1;
    @(negedge clk);
    ls_err_evt = 1'b0;
    chk("R10 not yet at k+1", 8'h01);
    @(negedge clk);
    chk("R10 shown at k+2", 8'h06);
    rd_lsr = 1'b1;
    @(negedge clk);
    rd_lsr = 1'b0;
    chk("R10 clear not yet at k+1", 8'h06);
    @(negedge clk);
    chk("R10 cleared at k+2", 8'h01);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    t_single();
    t_priority();
    t_timeout();
    t_enable();
    t_iir_read();
    t_timing();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule